// File: doc/BRIEF.md
# Oscillator Wake-Up Delay Timer

This block keeps the core clock gated after a reset or an exit from power-down until the chosen oscillator has had time to settle. It runs on the raw oscillator clock. A slow reference enable marks fixed time intervals of one tick period each. The length of the hold-off depends on a 3-bit source code, sampled once at the start of each sequence:

- Crystal sources wait for a fixed number of oscillator cycles, then for a fixed interval counted in reference ticks.
- The internal RC source waits only for a tick interval.
- The slow oscillator and external clock inputs wait only for a short cycle count.

The sequence is a four-state machine.

- `ST_LAUNCH`: entered on reset and on every `start` pulse. It samples `src_sel`.
- `ST_CYCLES`: counts oscillator clock edges.
- `ST_MICROS`: counts reference ticks.
- `ST_READY`: the terminal state.

The transitions are:

- launch-to-cycles: any non-RC source.
- launch-to-micros: RC source.
- cycles-to-micros: crystal, once the cycle count expires.
- cycles-to-ready: slow or external, once the cycle count expires.
- micros-to-ready: once the tick count expires.
- any-to-launch: `start`, which takes priority over every other transition.

The registered `clk_ready` output drives the core clock enable.

Top module: `wake_delay_timer`

## Requirements
- R1: While `rst_n` is low, `clk_ready` is 0. On release of reset, a full wait for the source on `src_sel` begins with no `start` pulse. For source 5, `clk_ready` rises after the 33rd rising edge following release.
- R2: Codes 0, 1 and 2 (crystal) wait 1024 clock edges and then 80 reference ticks. With a tick every 4 cycles, the latency from the start edge lies between 1342 and 1345 edges.
- R3: Code 3 (RC) waits 250 reference ticks with no cycle phase. With a tick every 4 cycles, the latency lies between 998 and 1001 edges.
- R4: Codes 4 (slow oscillator) and 5 (external) wait 32 edges. `clk_ready` is first seen high after the 33rd edge following the edge that sampled `start`.
- R5: Unused codes 6 and 7 behave exactly like code 5.
- R6: A `start` pulse during a wait abandons it and keeps `clk_ready` low. A full new wait is measured from the new pulse.
- R7: A `start` pulse while `clk_ready` is high drives it low after that edge. A full wait follows.
- R8: Once high, `clk_ready` stays high until the next `start` pulse.
- R9: `src_sel` is sampled only at the edge that ends the launch cycle. Later changes do not alter the running wait.
- R10: `us_tick` has no effect during the cycle phase. A code-5 wait lasts 33 edges whether ticks come every cycle or never.
- R11: If `start` is sampled at the same edge on which the wait would expire, `start` wins. `clk_ready` stays low and a full new wait follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Raw oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset; release launches a wait |
| us_tick | input | 1 | One-cycle reference enable, one per tick period |
| src_sel | input | 3 | Clock source code (0-2 crystal, 3 RC, 4 slow, 5-7 external) |
| start | input | 1 | Wake/restart pulse, sampled at the rising edge |
| clk_ready | output | 1 | Registered clock-ready flag for the core clock enable |

## Verification
Expiry of the running wait and arrival of a new `start` pulse can fall on the same edge. The bench provokes this on a code-5 wait by raising `start` so that it is sampled at exactly the 33rd edge, where `clk_ready` would otherwise rise. The case passes only if `clk_ready` stays low across that edge and then rises exactly 33 edges after it. Restarts in mid-wait and while ready are exercised separately, to tell those paths apart from the collision case.

// File: rtl/wake_delay_pkg.sv
package wake_delay_pkg;

    typedef enum logic [1:0] {
        ST_LAUNCH = 2'd0,
        ST_CYCLES = 2'd1,
        ST_MICROS = 2'd2,
        ST_READY  = 2'd3
    } wake_state_t;

    typedef enum logic [1:0] {
        CLS_XTAL = 2'd0,
        CLS_RC   = 2'd1,
        CLS_SLOW = 2'd2
    } src_class_t;

    localparam int SRC_W = 3;

    function automatic src_class_t classify_src(input logic [SRC_W-1:0] code);
        src_class_t cls;
        case (code)
            3'd0, 3'd1, 3'd2: cls = CLS_XTAL;
            3'd3:             cls = CLS_RC;
            default:          cls = CLS_SLOW;
        endcase
        return cls;
    endfunction

endpackage

// File: rtl/wake_span_counter.sv
module wake_span_counter #(
    parameter int WIDTH = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [WIDTH-1:0] limit,
    output logic             at_last
);

    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] last_val;

    assign last_val = limit - WIDTH'(1);
    assign at_last  = en && (cnt_q == last_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (en) begin
            if (cnt_q == last_val) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + WIDTH'(1);
            end
        end
    end

    // R2: a counting phase never runs past its limit
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt_q < limit));

    // R6: a clear always returns the span to its first count
    p_clear_restarts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

endmodule

// File: rtl/wake_seq_fsm.sv
module wake_seq_fsm
    import wake_delay_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SRC_W-1:0] src_sel,
    input  logic             cyc_last,
    input  logic             tick_last,
    output logic             cyc_run,
    output logic             tick_run,
    output src_class_t       src_class,
    output logic             ready
);

    wake_state_t state_q, state_d;
    src_class_t  cls_q;
    src_class_t  cls_now;
    logic        ready_q;

    assign cls_now = classify_src(src_sel);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LAUNCH: begin
                if (cls_now == CLS_RC) begin
                    state_d = ST_MICROS;
                end else begin
                    state_d = ST_CYCLES;
                end
            end
            ST_CYCLES: begin
                if (cyc_last) begin
                    state_d = (cls_q == CLS_XTAL) ? ST_MICROS : ST_READY;
                end
            end
            ST_MICROS: begin
                if (tick_last) begin
                    state_d = ST_READY;
                end
            end
            ST_READY: begin
                state_d = ST_READY;
            end
        endcase
        if (start) begin
            state_d = ST_LAUNCH;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LAUNCH;
            cls_q   <= CLS_SLOW;
        end else begin
            state_q <= state_d;
            if (state_q == ST_LAUNCH) begin
                cls_q <= cls_now;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
        end else begin
            ready_q <= (state_d == ST_READY);
        end
    end

    assign ready     = ready_q;
    assign cyc_run   = (state_q == ST_CYCLES) && !start;
    assign tick_run  = (state_q == ST_MICROS) && !start;
    assign src_class = cls_q;

    // R7: a start pulse always pulls ready low at the next edge
    p_start_drops_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !ready);

    // R8: ready is sticky until a new start pulse
    p_ready_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !start) |=> ready);

    // R2: ready only rises at the end of a counting phase
    p_rise_from_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(state_q) == ST_CYCLES || $past(state_q) == ST_MICROS));

    // R3: an RC wait never enters the cycle phase
    p_rc_skips_cycles_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CYCLES) |-> (cls_q != CLS_RC));

    // R1: ready is low during a launch cycle
    p_launch_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LAUNCH) |-> !ready);

endmodule

// File: rtl/wake_delay_timer.sv
module wake_delay_timer
    import wake_delay_pkg::*;
#(
    parameter int XTAL_CYCLES   = 1024,
    parameter int SLOW_CYCLES   = 32,
    parameter int TICK_NS       = 1000,
    parameter int XTAL_EXTRA_NS = 80000,
    parameter int RC_WAIT_NS    = 250000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       us_tick,
    input  logic [2:0] src_sel,
    input  logic       start,
    output logic       clk_ready
);

    localparam int XTAL_TICKS = XTAL_EXTRA_NS / TICK_NS;
    localparam int RC_TICKS   = RC_WAIT_NS / TICK_NS;
    localparam int CYC_MAX    = (XTAL_CYCLES > SLOW_CYCLES) ? XTAL_CYCLES : SLOW_CYCLES;
    localparam int TICK_MAX   = (XTAL_TICKS > RC_TICKS) ? XTAL_TICKS : RC_TICKS;
    localparam int CYC_W      = $clog2(CYC_MAX + 1);
    localparam int TICK_W     = $clog2(TICK_MAX + 1);

    logic              cyc_run, tick_run;
    logic              cyc_last, tick_last;
    src_class_t        src_class;
    logic [CYC_W-1:0]  cyc_limit;
    logic [TICK_W-1:0] tick_limit;

    assign cyc_limit  = (src_class == CLS_XTAL) ? CYC_W'(XTAL_CYCLES) : CYC_W'(SLOW_CYCLES);
    assign tick_limit = (src_class == CLS_RC)   ? TICK_W'(RC_TICKS)   : TICK_W'(XTAL_TICKS);

    wake_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .src_sel   (src_sel),
        .cyc_last  (cyc_last),
        .tick_last (tick_last),
        .cyc_run   (cyc_run),
        .tick_run  (tick_run),
        .src_class (src_class),
        .ready     (clk_ready)
    );

    wake_span_counter #(.WIDTH(CYC_W)) u_cycles (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!cyc_run),
        .en      (cyc_run),
        .limit   (cyc_limit),
        .at_last (cyc_last)
    );

    wake_span_counter #(.WIDTH(TICK_W)) u_ticks (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!tick_run),
        .en      (tick_run && us_tick),
        .limit   (tick_limit),
        .at_last (tick_last)
    );

endmodule

// File: tb/wake_delay_timer_tb.sv
module wake_delay_timer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TP         = 4;
    localparam int SLOW_LAT   = 33;
    localparam int XT_MIN     = 1342;
    localparam int XT_MAX     = 1345;
    localparam int RC_MIN     = 998;
    localparam int RC_MAX     = 1001;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       us_tick = 1'b0;
    logic [2:0] src_sel = 3'd5;
    logic       start = 1'b0;
    logic       clk_ready;

    int checks = 0;
    int errors = 0;
    int tick_period = TP;
    int phase = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wake_delay_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .us_tick   (us_tick),
        .src_sel   (src_sel),
        .start     (start),
        .clk_ready (clk_ready)
    );

    initial begin
        forever begin
            @(negedge clk);
            phase++;
            us_tick = (tick_period != 0) && ((phase % tick_period) == 0);
        end
    end

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_rng(input string tag, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
        end
    endtask

    // pulse start so it is sampled at one edge; returns at the following negedge
    task automatic do_start();
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
    endtask

    // count edges until ready is seen; optional source change after the launch edge
    task automatic wait_ready(input int max, input int alt_src, output int lat);
        lat = -1;
        for (int k = 1; k <= max; k++) begin
            @(negedge clk);
            if (k == 1 && alt_src >= 0) src_sel = 3'(alt_src);
            if (clk_ready) begin
                lat = k;
                break;
            end
        end
    endtask

    task automatic t_reset();
        int lat;
        src_sel = 3'd5;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_eq("R1 ready low in reset", int'(clk_ready), 0);
        rst_n = 1'b1;
        wait_ready(200, -1, lat);
        check_eq("R1 latency after reset release", lat, SLOW_LAT);
    endtask

    task automatic t_crystal(input int code);
        int lat;
        src_sel = 3'(code);
        do_start();
        check_eq("R7 ready low after start", int'(clk_ready), 0);
        wait_ready(3000, -1, lat);
        check_rng($sformatf("R2 crystal code %0d latency", code), lat, XT_MIN, XT_MAX);
    endtask

    task automatic t_rc();
        int lat;
        src_sel = 3'd3;
        do_start();
        wait_ready(3000, -1, lat);
        check_rng("R3 RC latency", lat, RC_MIN, RC_MAX);
    endtask

    task automatic t_slow(input int code, input string tag);
        int lat;
        src_sel = 3'(code);
        do_start();
        wait_ready(200, -1, lat);
        check_eq($sformatf("%s code %0d latency", tag, code), lat, SLOW_LAT);
    endtask

    task automatic t_sticky();
        int low_seen = 0;
        repeat (50) begin
            @(negedge clk);
            if (!clk_ready) low_seen++;
        end
        check_eq("R8 ready held for 50 cycles", low_seen, 0);
    endtask

    task automatic t_restart();
        int lat;
        int hi_seen = 0;
        src_sel = 3'd5;
        do_start();
        repeat (20) begin
            @(negedge clk);
            if (clk_ready) hi_seen++;
        end
        do_start();
        check_eq("R6 ready low through restart", hi_seen + int'(clk_ready), 0);
        wait_ready(200, -1, lat);
        check_eq("R6 latency from new start", lat, SLOW_LAT);
    endtask

    task automatic t_collide();
        int lat;
        int hi_seen = 0;
        src_sel = 3'd5;
        do_start();
        repeat (SLOW_LAT - 1) begin
            @(negedge clk);
            if (clk_ready) hi_seen++;
        end
        do_start();
        check_eq("R11 ready low when start meets expiry", hi_seen + int'(clk_ready), 0);
        wait_ready(200, -1, lat);
        check_eq("R11 full wait after collision", lat, SLOW_LAT);
    endtask

    task automatic t_src_change();
        int lat;
        src_sel = 3'd5;
        do_start();
        wait_ready(3000, 3, lat);
        check_eq("R9 change to RC after launch ignored", lat, SLOW_LAT);
        src_sel = 3'd3;
        do_start();
        wait_ready(3000, 5, lat);
        check_rng("R9 change to external after launch ignored", lat, RC_MIN, RC_MAX);
    endtask

    task automatic t_tick_ignored();
        int lat;
        tick_period = 1;
        src_sel = 3'd5;
        do_start();
        wait_ready(200, -1, lat);
        check_eq("R10 ticks every cycle", lat, SLOW_LAT);
        tick_period = 0;
        do_start();
        wait_ready(200, -1, lat);
        check_eq("R10 no ticks", lat, SLOW_LAT);
        tick_period = TP;
    endtask

    initial begin
        t_reset();
        t_sticky();
        t_crystal(0);
        t_crystal(1);
        t_crystal(2);
        t_rc();
        t_slow(4, "R4");
        t_slow(5, "R4");
        t_slow(6, "R5");
        t_slow(7, "R5");
        t_restart();
        t_collide();
        t_src_change();
        t_tick_ignored();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule